// File: doc/BRIEF.md
# Queued Conversion Command FIFO

This block sits between software and a converter back end. Software pushes conversion command words into a short command queue through a register-style push port. An operating-mode input decides whether and when queued commands are handed to the back end. The back end returns one result per command. A 4-bit tag in each command selects which result queue takes the answer. Results whose tag matches this block's own queue number go into a local result queue, which software drains through a pop port. Results with any other tag go out on a forward port.

With the back end model and DMA left out, the block can stand in for an immediate-command register. To set this up, software clears the fill enable, selects interrupt draining and sets the mode to continuous software-triggered. Every pushed command then leaves at once, and its result raises the drain interrupt. Software reads the command count before pushing so that it does not overflow the queue.

The block keeps at most one command in flight. The mode can be turned off at any time. A command already issued still completes, and the transfer-state output then reads idle, so software can poll for a safe point at which to change the queue.

Top module: `conv_cmd_queue`

## Requirements
- R1: After reset, both queue counts read 0, the transfer state reads 2'b00 (idle), both sticky flags are low, and no command-valid or request output is asserted.
- R2: The command queue holds at most 4 entries, and `cmd_count_o` tracks accepted pushes minus issued commands. A push while the count is 4 is ignored and sets the sticky `ovf_o`. Writing 1 to `flag_clr_i[0]` clears it. A set in the same cycle wins over the clear.
- R3: A pulse on `flush_i` empties the command queue, so the count reads 0 after that edge. The flush wins over a push in the same cycle, and that push does not set `ovf_o`.
- R4: `mode_i` encodes 2'b00 off (2'b11 acts the same), 2'b01 continuous with software trigger, and 2'b10 continuous with external trigger. `xfer_state_o` encodes 2'b00 idle, 2'b01 waiting for trigger, and 2'b10 triggered. In software-trigger mode, the state reads triggered one edge after leaving off.
- R5: In external-trigger mode, the state goes from idle to waiting and issues nothing. It becomes triggered at the first edge where `trig_i` is high.
- R6: `be_cmd_valid_o` is high only while the state is triggered, the mode is not off, the queue is non-empty and no command is in flight. Commands leave in push order. A handshake marks a command in flight until the next `be_res_valid_i`.
- R7: A result whose tag equals the block's own queue number (5, the tag being command bits [15:12]) enters the result queue. Any other tag appears on `fwd_valid_o`, `fwd_tag_o` and `fwd_data_o` in the same cycle and is not queued.
- R8: The result queue holds 4 entries, and results that arrive while it is full are dropped. `res_data_o` shows the oldest result, and `res_pop_i` removes it. A pop while the queue is empty returns 0 and sets the sticky `udf_o`. Writing 1 to `flag_clr_i[1]` clears it.
- R9: `drain_irq_o` is high while `drain_en_i` is 1, `drain_sel_i` is 0 and the result queue is non-empty. With `drain_sel_i` at 1, the same condition drives `drain_dma_o` instead.
- R10: While `fill_en_i` is 1 and the command queue is not full, a fill request goes to `fill_irq_o` when `fill_sel_i` is 0, or to `fill_dma_o` when it is 1. With `fill_en_i` at 0, neither output asserts.
- R11: `uflow_irq_o` is high while the state is triggered, the command queue is empty and `uflow_ie_i` is 1. It never asserts when `uflow_ie_i` is 0.
- R12: With the mode off, nothing is issued and queued commands stay in the queue. A command in flight completes, and the state reads idle after the first edge at which nothing is in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Operating mode |
| trig_i | input | 1 | External trigger |
| flush_i | input | 1 | Discard all queued commands |
| fill_en_i | input | 1 | Enable fill requests |
| fill_sel_i | input | 1 | Fill request target: 0 interrupt, 1 DMA |
| drain_en_i | input | 1 | Enable drain requests |
| drain_sel_i | input | 1 | Drain request target: 0 interrupt, 1 DMA |
| uflow_ie_i | input | 1 | Enable the underflow interrupt |
| cmd_push_i | input | 1 | Push a command |
| cmd_data_i | input | 16 | Command word, tag in [15:12] |
| res_pop_i | input | 1 | Pop a result |
| res_data_o | output | 16 | Oldest result, 0 when empty |
| flag_clr_i | input | 2 | Write-1 clear: [0] overflow, [1] underflow |
| cmd_count_o | output | 3 | Commands queued |
| res_count_o | output | 3 | Results queued |
| xfer_state_o | output | 2 | Transfer state |
| ovf_o | output | 1 | Sticky command overflow |
| udf_o | output | 1 | Sticky result underflow |
| be_cmd_valid_o | output | 1 | Command offered to the back end |
| be_cmd_ready_i | input | 1 | Back end accepts the command |
| be_cmd_o | output | 16 | Command to the back end |
| be_res_valid_i | input | 1 | Result arriving |
| be_res_tag_i | input | 4 | Tag of the arriving result |
| be_res_data_i | input | 16 | Arriving result data |
| fwd_valid_o | output | 1 | Result for another queue |
| fwd_tag_o | output | 4 | Its tag |
| fwd_data_o | output | 16 | Its data |
| fill_irq_o | output | 1 | Fill request as interrupt |
| fill_dma_o | output | 1 | Fill request as DMA |
| drain_irq_o | output | 1 | Drain request as interrupt |
| drain_dma_o | output | 1 | Drain request as DMA |
| uflow_irq_o | output | 1 | Command queue empty while triggered |

## Verification
Push counts are swept from 0 to 6 in off mode, where the queue cannot drain. This separates correct saturation at four entries, and the sticky overflow, from simple counting.

All sixteen tags are sent through one at a time in software-trigger mode. This tells correct routing to the local result queue apart from forwarding. A burst of five results separates dropping when the result queue is full from overwriting.

The fill and drain enable/select pairs are swept over every combination at several queue levels. Two further runs confirm that nothing moves before the trigger, and that the state waits for the in-flight result before it reads idle: one starts external-trigger mode, the other switches the mode off while a command is in flight.

// File: rtl/cmdq_pkg.sv
package cmdq_pkg;
  localparam int TAG_W = 4;

  typedef enum logic [1:0] {
    MODE_OFF = 2'b00,
    MODE_SW  = 2'b01,
    MODE_EXT = 2'b10,
    MODE_RSV = 2'b11
  } mode_e;

  typedef enum logic [1:0] {
    XS_IDLE = 2'b00,
    XS_WAIT = 2'b01,
    XS_TRIG = 2'b10
  } xstate_e;
endpackage

// File: rtl/cmdq_fifo.sv
module cmdq_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 4,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             push_i,
  input  logic [W-1:0]     din_i,
  input  logic             pop_i,
  output logic [W-1:0]     dout_o,
  output logic [CNT_W-1:0] count_o,
  output logic             full_o,
  output logic             empty_o
);
  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] cnt_q;
  logic             do_push, do_pop;

  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i && !full_o && !flush_i;
  assign do_pop  = pop_i && !empty_o && !flush_i;
  assign dout_o  = mem_q[rd_q];
  assign count_o = cnt_q;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else if (flush_i) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= nxt(wr_q);
      if (do_pop)  rd_q <= nxt(rd_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_q] <= din_i;
  end
endmodule

// File: rtl/cmdq_xfer_ctrl.sv
module cmdq_xfer_ctrl
  import cmdq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] mode_i,
  input  logic       trig_i,
  input  logic       cmd_avail_i,
  input  logic       cmd_ready_i,
  input  logic       res_valid_i,
  output logic       cmd_valid_o,
  output logic       issue_o,
  output logic [1:0] state_o
);
  xstate_e state_q, state_d;
  logic    inflight_q;
  logic    mode_on;

  assign mode_on     = (mode_i == MODE_SW) || (mode_i == MODE_EXT);
  assign cmd_valid_o = (state_q == XS_TRIG) && mode_on && cmd_avail_i && !inflight_q;
  assign issue_o     = cmd_valid_o && cmd_ready_i;
  assign state_o     = state_q;

  always_comb begin
    state_d = state_q;
    if (!mode_on) begin
      // in-flight command must finish before idle
      if (!inflight_q || res_valid_i) state_d = XS_IDLE;
    end else begin
      unique case (state_q)
        XS_IDLE: state_d = (mode_i == MODE_SW) ? XS_TRIG : XS_WAIT;
        XS_WAIT: if (mode_i == MODE_SW || trig_i) state_d = XS_TRIG;
        default: state_d = XS_TRIG;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= XS_IDLE;
      inflight_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (issue_o)          inflight_q <= 1'b1;
      else if (res_valid_i) inflight_q <= 1'b0;
    end
  end
endmodule

// File: rtl/cmdq_req_gen.sv
module cmdq_req_gen #(
  parameter bit REQ_REG = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fill_en_i,
  input  logic fill_sel_i,
  input  logic cmd_full_i,
  input  logic cmd_empty_i,
  input  logic drain_en_i,
  input  logic drain_sel_i,
  input  logic res_empty_i,
  input  logic uflow_ie_i,
  input  logic trig_i,
  output logic fill_irq_o,
  output logic fill_dma_o,
  output logic drain_irq_o,
  output logic drain_dma_o,
  output logic uflow_irq_o
);
  logic [4:0] req_d;
  logic       fill_want, drain_want;

  assign fill_want  = fill_en_i && !cmd_full_i;
  assign drain_want = drain_en_i && !res_empty_i;
  assign req_d = {fill_want && !fill_sel_i, fill_want && fill_sel_i,
                  drain_want && !drain_sel_i, drain_want && drain_sel_i,
                  uflow_ie_i && trig_i && cmd_empty_i};

  generate
    if (REQ_REG) begin : g_reg
      logic [4:0] req_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) req_q <= '0;
        else         req_q <= req_d;
      end
      assign {fill_irq_o, fill_dma_o, drain_irq_o, drain_dma_o, uflow_irq_o} = req_q;
    end else begin : g_comb
      assign {fill_irq_o, fill_dma_o, drain_irq_o, drain_dma_o, uflow_irq_o} = req_d;
    end
  endgenerate
endmodule

// File: rtl/conv_cmd_queue.sv
module conv_cmd_queue
  import cmdq_pkg::*;
#(
  parameter int CMD_W    = 16,
  parameter int RES_W    = 16,
  parameter int CQ_DEPTH = 4,
  parameter int RQ_DEPTH = 4,
  parameter int OWN_TAG  = 5
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic [1:0]                      mode_i,
  input  logic                            trig_i,
  input  logic                            flush_i,
  input  logic                            fill_en_i,
  input  logic                            fill_sel_i,
  input  logic                            drain_en_i,
  input  logic                            drain_sel_i,
  input  logic                            uflow_ie_i,
  input  logic                            cmd_push_i,
  input  logic [CMD_W-1:0]                cmd_data_i,
  input  logic                            res_pop_i,
  output logic [RES_W-1:0]                res_data_o,
  input  logic [1:0]                      flag_clr_i,
  output logic [$clog2(CQ_DEPTH+1)-1:0]   cmd_count_o,
  output logic [$clog2(RQ_DEPTH+1)-1:0]   res_count_o,
  output logic [1:0]                      xfer_state_o,
  output logic                            ovf_o,
  output logic                            udf_o,
  output logic                            be_cmd_valid_o,
  input  logic                            be_cmd_ready_i,
  output logic [CMD_W-1:0]                be_cmd_o,
  input  logic                            be_res_valid_i,
  input  logic [3:0]                      be_res_tag_i,
  input  logic [RES_W-1:0]                be_res_data_i,
  output logic                            fwd_valid_o,
  output logic [3:0]                      fwd_tag_o,
  output logic [RES_W-1:0]                fwd_data_o,
  output logic                            fill_irq_o,
  output logic                            fill_dma_o,
  output logic                            drain_irq_o,
  output logic                            drain_dma_o,
  output logic                            uflow_irq_o
);
  logic cq_full, cq_empty, rq_full, rq_empty;
  logic issue, tag_hit;
  logic [RES_W-1:0] rq_head;
  logic ovf_q, udf_q;

  cmdq_fifo #(.W(CMD_W), .DEPTH(CQ_DEPTH)) u_cmd_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (flush_i),
    .push_i  (cmd_push_i),
    .din_i   (cmd_data_i),
    .pop_i   (issue),
    .dout_o  (be_cmd_o),
    .count_o (cmd_count_o),
    .full_o  (cq_full),
    .empty_o (cq_empty)
  );

  cmdq_xfer_ctrl u_xfer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mode_i      (mode_i),
    .trig_i      (trig_i),
    .cmd_avail_i (!cq_empty),
    .cmd_ready_i (be_cmd_ready_i),
    .res_valid_i (be_res_valid_i),
    .cmd_valid_o (be_cmd_valid_o),
    .issue_o     (issue),
    .state_o     (xfer_state_o)
  );

  assign tag_hit     = (be_res_tag_i == TAG_W'(OWN_TAG));
  assign fwd_valid_o = be_res_valid_i && !tag_hit;
  assign fwd_tag_o   = be_res_tag_i;
  assign fwd_data_o  = be_res_data_i;

  cmdq_fifo #(.W(RES_W), .DEPTH(RQ_DEPTH)) u_res_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (1'b0),
    .push_i  (be_res_valid_i && tag_hit),
    .din_i   (be_res_data_i),
    .pop_i   (res_pop_i),
    .dout_o  (rq_head),
    .count_o (res_count_o),
    .full_o  (rq_full),
    .empty_o (rq_empty)
  );

  assign res_data_o = rq_empty ? '0 : rq_head;

  // sticky flags: set beats clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovf_q <= 1'b0;
      udf_q <= 1'b0;
    end else begin
      ovf_q <= (cmd_push_i && cq_full && !flush_i) || (ovf_q && !flag_clr_i[0]);
      udf_q <= (res_pop_i && rq_empty) || (udf_q && !flag_clr_i[1]);
    end
  end
  assign ovf_o = ovf_q;
  assign udf_o = udf_q;

  cmdq_req_gen #(.REQ_REG(1'b0)) u_req (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .fill_en_i   (fill_en_i),
    .fill_sel_i  (fill_sel_i),
    .cmd_full_i  (cq_full),
    .cmd_empty_i (cq_empty),
    .drain_en_i  (drain_en_i),
    .drain_sel_i (drain_sel_i),
    .res_empty_i (rq_empty),
    .uflow_ie_i  (uflow_ie_i),
    .trig_i      (xfer_state_o == XS_TRIG),
    .fill_irq_o  (fill_irq_o),
    .fill_dma_o  (fill_dma_o),
    .drain_irq_o (drain_irq_o),
    .drain_dma_o (drain_dma_o),
    .uflow_irq_o (uflow_irq_o)
  );

  logic unused_full;
  assign unused_full = rq_full;
endmodule

// File: rtl/conv_cmd_queue_chk.sv
module conv_cmd_queue_chk #(
  parameter int CQ_DEPTH = 4,
  parameter int RQ_DEPTH = 4,
  parameter int RES_W    = 16
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic [1:0]                    mode_i,
  input logic                          flush_i,
  input logic                          fill_en_i,
  input logic                          uflow_ie_i,
  input logic                          cmd_push_i,
  input logic                          res_pop_i,
  input logic [RES_W-1:0]              res_data_o,
  input logic [1:0]                    flag_clr_i,
  input logic [$clog2(CQ_DEPTH+1)-1:0] cmd_count_o,
  input logic [$clog2(RQ_DEPTH+1)-1:0] res_count_o,
  input logic [1:0]                    xfer_state_o,
  input logic                          ovf_o,
  input logic                          udf_o,
  input logic                          be_cmd_valid_o,
  input logic                          fill_irq_o,
  input logic                          fill_dma_o,
  input logic                          drain_irq_o,
  input logic                          drain_dma_o,
  input logic                          uflow_irq_o
);
  p_no_overflow_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(cmd_count_o) <= CQ_DEPTH);

  p_ovf_set_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_push_i && int'(cmd_count_o) == CQ_DEPTH && !flush_i |=> ovf_o);

  p_ovf_sticky_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o && !flag_clr_i[0] |=> ovf_o);

  p_flush_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> cmd_count_o == '0);

  p_issue_trig_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    be_cmd_valid_o |-> xfer_state_o == 2'b10 && cmd_count_o != '0);

  p_res_bound_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(res_count_o) <= RQ_DEPTH);

  p_pop_empty_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_pop_i && res_count_o == '0 |-> res_data_o == '0 ##1 udf_o);

  p_drain_excl_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(drain_irq_o && drain_dma_o));

  p_drain_nonempty_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drain_irq_o || drain_dma_o) |-> res_count_o != '0);

  p_fill_off_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fill_en_i |-> !fill_irq_o && !fill_dma_o);

  p_uflow_off_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !uflow_ie_i |-> !uflow_irq_o);

  p_no_issue_off_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b00 || mode_i == 2'b11) |-> !be_cmd_valid_o);
endmodule

bind conv_cmd_queue conv_cmd_queue_chk #(
  .CQ_DEPTH(CQ_DEPTH), .RQ_DEPTH(RQ_DEPTH), .RES_W(RES_W)
) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .mode_i         (mode_i),
  .flush_i        (flush_i),
  .fill_en_i      (fill_en_i),
  .uflow_ie_i     (uflow_ie_i),
  .cmd_push_i     (cmd_push_i),
  .res_pop_i      (res_pop_i),
  .res_data_o     (res_data_o),
  .flag_clr_i     (flag_clr_i),
  .cmd_count_o    (cmd_count_o),
  .res_count_o    (res_count_o),
  .xfer_state_o   (xfer_state_o),
  .ovf_o          (ovf_o),
  .udf_o          (udf_o),
  .be_cmd_valid_o (be_cmd_valid_o),
  .fill_irq_o     (fill_irq_o),
  .fill_dma_o     (fill_dma_o),
  .drain_irq_o    (drain_irq_o),
  .drain_dma_o    (drain_dma_o),
  .uflow_irq_o    (uflow_irq_o)
);

// File: tb/conv_cmd_queue_test.sv
`timescale 1ns/1ps
module conv_cmd_queue_test;
  localparam int LAT = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [1:0]  mode = 2'b00;
  logic        trig = 0, flush = 0, fill_en = 0, fill_sel = 0;
  logic        drain_en = 0, drain_sel = 0, uflow_ie = 0;
  logic        push = 0, pop = 0;
  logic [15:0] cmd = '0;
  logic [1:0]  clr = '0;
  logic [15:0] res_data;
  logic [2:0]  cmd_cnt, res_cnt;
  logic [1:0]  xstate;
  logic        ovf, udf, be_valid, fwd_valid;
  logic [15:0] be_cmd, fwd_data;
  logic [3:0]  fwd_tag;
  logic        fill_irq, fill_dma, drain_irq, drain_dma, uflow_irq;
  logic        be_res_valid;
  logic [3:0]  be_res_tag;
  logic [15:0] be_res_data;

  conv_cmd_queue uut (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .trig_i(trig), .flush_i(flush),
    .fill_en_i(fill_en), .fill_sel_i(fill_sel), .drain_en_i(drain_en),
    .drain_sel_i(drain_sel), .uflow_ie_i(uflow_ie), .cmd_push_i(push),
    .cmd_data_i(cmd), .res_pop_i(pop), .res_data_o(res_data), .flag_clr_i(clr),
    .cmd_count_o(cmd_cnt), .res_count_o(res_cnt), .xfer_state_o(xstate),
    .ovf_o(ovf), .udf_o(udf), .be_cmd_valid_o(be_valid), .be_cmd_ready_i(1'b1),
    .be_cmd_o(be_cmd), .be_res_valid_i(be_res_valid), .be_res_tag_i(be_res_tag),
    .be_res_data_i(be_res_data), .fwd_valid_o(fwd_valid), .fwd_tag_o(fwd_tag),
    .fwd_data_o(fwd_data), .fill_irq_o(fill_irq), .fill_dma_o(fill_dma),
    .drain_irq_o(drain_irq), .drain_dma_o(drain_dma), .uflow_irq_o(uflow_irq)
  );

  function automatic logic [15:0] resval(input logic [15:0] c);
    return {c[11:0], c[15:12]} ^ 16'h5A00;
  endfunction

  // fixed-latency back end
  logic [LAT-1:0] v_pipe;
  logic [15:0]    d_pipe [LAT];
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) v_pipe <= '0;
    else begin
      v_pipe <= {v_pipe[LAT-2:0], be_valid};
      d_pipe[0] <= be_cmd;
      for (int i = 1; i < LAT; i++) d_pipe[i] <= d_pipe[i-1];
    end
  end
  assign be_res_valid = v_pipe[LAT-1];
  assign be_res_tag   = d_pipe[LAT-1][15:12];
  assign be_res_data  = resval(d_pipe[LAT-1]);

  int fwd_cnt = 0;
  always @(posedge clk) if (fwd_valid) fwd_cnt <= fwd_cnt + 1;

  int checks = 0, errors = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic push_cmd(input logic [15:0] c);
    push = 1; cmd = c; step(); push = 0;
  endtask

  task automatic do_flush();
    flush = 1; step(); flush = 0;
  endtask

  task automatic pop_one();
    pop = 1; step(); pop = 0;
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    step(3);
    rst_n = 1;
    step();
    // R1 reset state
    chk("R1 cmd_cnt", cmd_cnt, 0);
    chk("R1 res_cnt", res_cnt, 0);
    chk("R1 state", xstate, 2'b00);
    chk("R1 flags", {ovf, udf}, 0);
    chk("R1 outs", {be_valid, fill_irq, fill_dma, drain_irq, drain_dma, uflow_irq}, 0);

    // R2 depth sweep in off mode
    for (int n = 0; n <= 6; n++) begin
      do_flush();
      clr = 2'b01; step(); clr = 0;
      for (int k = 0; k < n; k++) push_cmd(16'h5000 | 16'(k));
      chk("R2 count", cmd_cnt, (n > 4) ? 4 : n);
      chk("R2 ovf", ovf, (n > 4) ? 1 : 0);
    end
    clr = 2'b01; step(); clr = 0;
    chk("R2 ovf clear", ovf, 0);

    // R3 flush beats push
    do_flush();
    push_cmd(16'h5001); push_cmd(16'h5002);
    flush = 1; push = 1; cmd = 16'h5003; step(); flush = 0; push = 0;
    chk("R3 count", cmd_cnt, 0);
    chk("R3 no ovf", ovf, 0);

    // R10 fill sweep
    for (int n = 0; n <= 4; n++) begin
      do_flush();
      for (int k = 0; k < n; k++) push_cmd(16'h5100 | 16'(k));
      for (int e = 0; e < 2; e++)
        for (int s = 0; s < 2; s++) begin
          fill_en = e[0]; fill_sel = s[0]; step();
          chk("R10 fill_irq", fill_irq, (e == 1 && s == 0 && n < 4) ? 1 : 0);
          chk("R10 fill_dma", fill_dma, (e == 1 && s == 1 && n < 4) ? 1 : 0);
        end
    end
    fill_en = 0; fill_sel = 0;

    // R4 R6 R7 sw mode, ordered results
    do_flush();
    push_cmd(16'h5101); push_cmd(16'h5202); push_cmd(16'h5303);
    chk("R12 held while off", cmd_cnt, 3);
    chk("R4 idle", xstate, 2'b00);
    mode = 2'b01; step();
    chk("R4 triggered", xstate, 2'b10);
    step(25);
    chk("R6 drained", cmd_cnt, 0);
    chk("R7 queued", res_cnt, 3);
    chk("R6 order 0", res_data, resval(16'h5101)); pop_one();
    chk("R6 order 1", res_data, resval(16'h5202)); pop_one();
    chk("R6 order 2", res_data, resval(16'h5303)); pop_one();

    // R11 underflow irq
    uflow_ie = 1; step();
    chk("R11 irq on", uflow_irq, 1);
    uflow_ie = 0; step();
    chk("R11 irq off", uflow_irq, 0);

    // R7 tag sweep
    for (int t = 0; t < 16; t++) begin
      automatic int f0 = fwd_cnt;
      automatic int r0 = res_cnt;
      automatic logic [15:0] c = {4'(t), 12'(t * 37 + 1)};
      push_cmd(c);
      step(10);
      chk("R7 res delta", res_cnt - r0, (t == 5) ? 1 : 0);
      chk("R7 fwd delta", fwd_cnt - f0, (t == 5) ? 0 : 1);
      if (t == 5) begin
        chk("R7 data", res_data, resval(c));
        pop_one();
      end
    end

    // R8 full result queue drops fifth
    for (int k = 0; k < 5; k++) push_cmd(16'h5400 | 16'(k));
    step(30);
    chk("R8 full", res_cnt, 4);
    chk("R2 no ovf burst", ovf, 0);
    // R9 drain sweep non-empty
    for (int e = 0; e < 2; e++)
      for (int s = 0; s < 2; s++) begin
        drain_en = e[0]; drain_sel = s[0]; step();
        chk("R9 irq", drain_irq, (e == 1 && s == 0) ? 1 : 0);
        chk("R9 dma", drain_dma, (e == 1 && s == 1) ? 1 : 0);
      end
    for (int k = 0; k < 4; k++) begin
      chk("R8 pop data", res_data, resval(16'h5400 | 16'(k)));
      pop_one();
    end
    for (int e = 0; e < 2; e++)
      for (int s = 0; s < 2; s++) begin
        drain_en = e[0]; drain_sel = s[0]; step();
        chk("R9 empty", {drain_irq, drain_dma}, 0);
      end
    drain_en = 0; drain_sel = 0;
    chk("R8 empty zero", res_data, 0);
    chk("R8 udf before", udf, 0);
    pop_one();
    chk("R8 udf set", udf, 1);
    clr = 2'b10; step(); clr = 0;
    chk("R8 udf clear", udf, 0);

    // R5 external trigger
    mode = 2'b00; step();
    chk("R12 idle", xstate, 2'b00);
    mode = 2'b10; step();
    chk("R5 waiting", xstate, 2'b01);
    push_cmd(16'h5777);
    step(5);
    chk("R5 no issue", {be_valid, cmd_cnt}, {1'b0, 3'd1});
    trig = 1; step(); trig = 0;
    chk("R5 triggered", xstate, 2'b10);
    step(10);
    chk("R5 result", res_data, resval(16'h5777));
    pop_one();

    // R12 disable during flight
    push_cmd(16'h5aaa); push_cmd(16'h5bbb);
    mode = 2'b00;
    while (!be_res_valid) begin
      chk("R12 hold state", xstate, 2'b10);
      chk("R12 no issue", be_valid, 0);
      step();
    end
    step();
    chk("R12 idle after", xstate, 2'b00);
    chk("R12 queue kept", cmd_cnt, 1);
    step(5);
    chk("R12 still kept", cmd_cnt, 1);
    do_flush();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule